// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a word-wide flash array controller. Each bus write reaches it as a one-clock strobe with the address and data word already latched. It follows the multi-cycle unlock protocol and turns each complete, well-formed sequence into a one-clock operation request for the program/erase engine. The request carries an operation code and the address and data of the sequence's final cycle. For the resume command it also carries a plane number.

Comparisons use only the low 11 address bits and the low data byte. Short commands (erase suspend, erase resume and a single-cycle identification exit) are accepted from idle without any unlock prefix. A six-cycle entry sequence switches the decoder into a sticky single-pulse programming mode, in which every write becomes a program request. While the engine reports that an embedded program is running, writes are dropped and flagged. A write that does not fit the expected next cycle ends the sequence silently.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is high and on the cycle after it, req_valid, wr_ignored and sp_mode are 0, and the decoder waits for the first unlock cycle.
- R2: Only wr_addr[10:0] and wr_data[7:0] are compared against command values. The first unlock cycle is 0x555/0xAA and the second is 0x2AA/0x55, so an address of 0xAAA is also accepted for the second unlock.
- R3: The unlock pair, then 0x555/0xA0, then any write, gives req_op 1 (program) with req_addr/req_data equal to that fourth write's address and data.
- R4: The unlock pair, 0x555/0x80, a second unlock pair, then 0x555/0x10, gives req_op 2 (chip erase).
- R5: The same five-cycle erase prefix followed by data 0x30 at any address gives req_op 3 (sector erase). Followed by data 0x60 at any address, it gives req_op 4 (sector lockdown). In both cases req_addr is the sixth write's address.
- R6: From idle, a single write of data 0xB0 at any address gives req_op 5 (suspend). A single write of data 0x30 gives req_op 6 (resume), with req_plane equal to wr_addr[19:18] of that write.
- R7: The unlock pair followed by 0x555/0x90 gives req_op 7 (identification entry). The unlock pair followed by 0x555/0xF0, or a single write of data 0xF0 from idle, gives req_op 8 (identification exit).
- R8: The unlock pair, 0x555/0xC0, then a write gives req_op 10 (protection lock) when its low address bits are 0x080 and data bit 1 is 0. At address 0x080 with data bit 1 set, it gives no request. At any other address it gives req_op 9 (protection program) with that write's address and data.
- R9: The erase prefix followed by 0x555/0xA0 gives req_op 11 and sets sp_mode. While sp_mode is 1, every accepted write, including command codes, gives req_op 1 with its own address and data. Only reset clears sp_mode.
- R10: A write strobed while engine_pgm_busy is 1 raises wr_ignored for one cycle, issues no request and leaves the sequence position unchanged.
- R11: A write that does not match the expected next cycle returns the decoder to idle without a request, so later cycles of the broken sequence do nothing.
- R12: req_valid and wr_ignored are registered. They are high for exactly the one cycle after the strobe that caused them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-clock bus write strobe |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | DATA_W | Latched write data |
| engine_pgm_busy | input | 1 | Embedded program in progress |
| req_valid | output | 1 | One-clock operation request |
| req_op | output | 4 | Operation code (see requirements) |
| req_addr | output | ADDR_W | Address of the final cycle |
| req_data | output | DATA_W | Data of the final cycle |
| req_plane | output | PLANE_W | Plane selected by the top address bits |
| wr_ignored | output | 1 | Write dropped because the engine was busy |
| sp_mode | output | 1 | Single-pulse programming mode active |

## Verification
The hardest condition to reach from the ports is single-pulse mode. Getting there needs a full six-cycle sequence, and once the mode is set it hides every other command. The bench therefore runs it last. Inside the mode it writes bytes that would otherwise be suspend, resume and unlock codes, then applies reset and shows that a suspend decodes normally again. A busy write in the middle of a program sequence also requires careful ordering: it is sent between the third and fourth cycles, so the program request that follows proves the sequence position was kept.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_AW = 11;
  localparam int CMP_DW = 8;

  localparam logic [CMP_AW-1:0] A_UNLK1 = 11'h555;
  localparam logic [CMP_AW-1:0] A_UNLK2 = 11'h2AA;
  localparam logic [CMP_AW-1:0] A_PLOCK = 11'h080;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_PROGRAM   = 4'd1,
    OP_CHIP_ERS  = 4'd2,
    OP_SECT_ERS  = 4'd3,
    OP_LOCKDOWN  = 4'd4,
    OP_SUSPEND   = 4'd5,
    OP_RESUME    = 4'd6,
    OP_ID_ENTER  = 4'd7,
    OP_ID_EXIT   = 4'd8,
    OP_PROT_PGM  = 4'd9,
    OP_PROT_LOCK = 4'd10,
    OP_SP_ENTER  = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_PROT, S_ERS0, S_ERS1, S_ERS2
  } seq_e;

  // Decoded view of one bus cycle
  typedef struct packed {
    logic a_unl1;
    logic a_unl2;
    logic a_plock;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_f0;
    logic d_c0;
    logic d_10;
    logic d_30;
    logic d_60;
    logic d_b0;
    logic keep_bit;
  } cyc_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int AW = CMP_AW,
  parameter int DW = CMP_DW
) (
  input  logic [AW-1:0] addr_lo,
  input  logic [DW-1:0] data_lo,
  output cyc_t          cyc
);

  always_comb begin
    cyc.a_unl1   = (addr_lo == A_UNLK1);
    cyc.a_unl2   = (addr_lo == A_UNLK2);
    cyc.a_plock  = (addr_lo == A_PLOCK);
    cyc.d_aa     = (data_lo == 8'hAA);
    cyc.d_55     = (data_lo == 8'h55);
    cyc.d_a0     = (data_lo == 8'hA0);
    cyc.d_80     = (data_lo == 8'h80);
    cyc.d_90     = (data_lo == 8'h90);
    cyc.d_f0     = (data_lo == 8'hF0);
    cyc.d_c0     = (data_lo == 8'hC0);
    cyc.d_10     = (data_lo == 8'h10);
    cyc.d_30     = (data_lo == 8'h30);
    cyc.d_60     = (data_lo == 8'h60);
    cyc.d_b0     = (data_lo == 8'hB0);
    cyc.keep_bit = data_lo[1];
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic busy,
  input  cyc_t cyc,
  output logic nxt_valid,
  output op_e  nxt_op,
  output logic nxt_ign,
  output logic sp_mode
);

  seq_e st, st_n;
  logic sp_n;

  always_comb begin
    st_n      = st;
    sp_n      = sp_mode;
    nxt_valid = 1'b0;
    nxt_op    = OP_NONE;
    nxt_ign   = 1'b0;
    if (stb) begin
      if (busy) begin
        nxt_ign = 1'b1;
      end else if (sp_mode) begin
        nxt_valid = 1'b1;
        nxt_op    = OP_PROGRAM;
      end else begin
        case (st)
          S_IDLE: begin
            if (cyc.d_b0) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_SUSPEND;
            end else if (cyc.d_30) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_RESUME;
            end else if (cyc.d_f0) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_ID_EXIT;
            end else if (cyc.a_unl1 && cyc.d_aa) begin
              st_n = S_UNL1;
            end
          end
          S_UNL1: st_n = (cyc.a_unl2 && cyc.d_55) ? S_UNL2 : S_IDLE;
          S_UNL2: begin
            st_n = S_IDLE;
            if (cyc.a_unl1) begin
              if (cyc.d_a0)      st_n = S_PGM;
              else if (cyc.d_80) st_n = S_ERS0;
              else if (cyc.d_c0) st_n = S_PROT;
              else if (cyc.d_90) begin
                nxt_valid = 1'b1;
                nxt_op    = OP_ID_ENTER;
              end else if (cyc.d_f0) begin
                nxt_valid = 1'b1;
                nxt_op    = OP_ID_EXIT;
              end
            end
          end
          S_PGM: begin
            st_n      = S_IDLE;
            nxt_valid = 1'b1;
            nxt_op    = OP_PROGRAM;
          end
          S_PROT: begin
            st_n = S_IDLE;
            if (cyc.a_plock) begin
              if (!cyc.keep_bit) begin
                nxt_valid = 1'b1;
                nxt_op    = OP_PROT_LOCK;
              end
            end else begin
              nxt_valid = 1'b1;
              nxt_op    = OP_PROT_PGM;
            end
          end
          S_ERS0: st_n = (cyc.a_unl1 && cyc.d_aa) ? S_ERS1 : S_IDLE;
          S_ERS1: st_n = (cyc.a_unl2 && cyc.d_55) ? S_ERS2 : S_IDLE;
          S_ERS2: begin
            st_n = S_IDLE;
            if (cyc.a_unl1 && cyc.d_10) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_CHIP_ERS;
            end else if (cyc.a_unl1 && cyc.d_a0) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_SP_ENTER;
              sp_n      = 1'b1;
            end else if (cyc.d_30) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_SECT_ERS;
            end else if (cyc.d_60) begin
              nxt_valid = 1'b1;
              nxt_op    = OP_LOCKDOWN;
            end
          end
          default: st_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      sp_mode <= 1'b0;
    end else begin
      st      <= st_n;
      sp_mode <= sp_n;
    end
  end

endmodule

// File: rtl/flash_cmd_out.sv
module flash_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int PLANE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nxt_valid,
  input  op_e                nxt_op,
  input  logic               nxt_ign,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic               req_valid,
  output logic [3:0]         req_op,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_data,
  output logic [PLANE_W-1:0] req_plane,
  output logic               wr_ignored
);

  localparam int PLANE_LSB = ADDR_W - PLANE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_op     <= OP_NONE;
      req_addr   <= '0;
      req_data   <= '0;
      req_plane  <= '0;
      wr_ignored <= 1'b0;
    end else begin
      req_valid  <= nxt_valid;
      req_op     <= nxt_op;
      wr_ignored <= nxt_ign;
      if (nxt_valid) begin
        req_addr  <= addr;
        req_data  <= data;
        req_plane <= addr[PLANE_LSB +: PLANE_W];
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int PLANE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               engine_pgm_busy,
  output logic               req_valid,
  output logic [3:0]         req_op,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_data,
  output logic [PLANE_W-1:0] req_plane,
  output logic               wr_ignored,
  output logic               sp_mode
);

  cyc_t cyc;
  logic nxt_valid, nxt_ign;
  op_e  nxt_op;

  flash_cmd_match #(.AW(CMP_AW), .DW(CMP_DW)) match_i (
    .addr_lo (wr_addr[CMP_AW-1:0]),
    .data_lo (wr_data[CMP_DW-1:0]),
    .cyc     (cyc)
  );

  flash_cmd_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .stb       (wr_stb),
    .busy      (engine_pgm_busy),
    .cyc       (cyc),
    .nxt_valid (nxt_valid),
    .nxt_op    (nxt_op),
    .nxt_ign   (nxt_ign),
    .sp_mode   (sp_mode)
  );

  flash_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLANE_W(PLANE_W)) out_i (
    .clk        (clk),
    .rst        (rst),
    .nxt_valid  (nxt_valid),
    .nxt_op     (nxt_op),
    .nxt_ign    (nxt_ign),
    .addr       (wr_addr),
    .data       (wr_data),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_plane  (req_plane),
    .wr_ignored (wr_ignored)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int PLANE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_stb,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               engine_pgm_busy,
  input logic               req_valid,
  input logic [3:0]         req_op,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [PLANE_W-1:0] req_plane,
  input logic               wr_ignored,
  input logic               sp_mode
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !wr_ignored && !sp_mode));

  assert_req_follows_write_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(wr_stb && !engine_pgm_busy));

  assert_busy_drops_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && engine_pgm_busy) |=> (wr_ignored && !req_valid));

  assert_ignore_needs_busy_R10: assert property (@(posedge clk) disable iff (rst)
    wr_ignored |-> $past(wr_stb && engine_pgm_busy));

  assert_sp_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    sp_mode |=> sp_mode);

  assert_sp_programs_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !engine_pgm_busy && sp_mode) |=>
      (req_valid && req_op == OP_PROGRAM && req_addr == $past(wr_addr)));

  assert_resume_plane_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_RESUME) |->
      req_plane == $past(wr_addr[ADDR_W-1 -: PLANE_W]));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .PLANE_W(PLANE_W)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .wr_stb          (wr_stb),
  .wr_addr         (wr_addr),
  .engine_pgm_busy (engine_pgm_busy),
  .req_valid       (req_valid),
  .req_op          (req_op),
  .req_addr        (req_addr),
  .req_plane       (req_plane),
  .wr_ignored      (wr_ignored),
  .sp_mode         (sp_mode)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        engine_pgm_busy = 1'b0;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [19:0] req_addr;
  logic [15:0] req_data;
  logic [1:0]  req_plane;
  logic        wr_ignored;
  logic        sp_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        g_valid, g_ign, g_sp;
  logic [3:0]  g_op;
  logic [19:0] g_addr;
  logic [15:0] g_data;
  logic [1:0]  g_plane;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .engine_pgm_busy(engine_pgm_busy), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_plane(req_plane),
    .wr_ignored(wr_ignored), .sp_mode(sp_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One write; outputs captured on the negedge after the sampling posedge
  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic busy = 1'b0);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d; engine_pgm_busy = busy;
    @(negedge clk);
    wr_stb = 1'b0; engine_pgm_busy = 1'b0;
    g_valid = req_valid; g_op = req_op; g_addr = req_addr; g_data = req_data;
    g_plane = req_plane; g_ign = wr_ignored; g_sp = sp_mode;
  endtask

  task automatic exp_req(input string tag, input logic [3:0] op,
                         input logic [19:0] a, input logic [15:0] d);
    chk({tag, " valid"}, g_valid, 1);
    chk({tag, " op"}, g_op, op);
    chk({tag, " addr"}, g_addr, a);
    chk({tag, " data"}, g_data, d);
  endtask

  task automatic exp_none(input string tag);
    chk({tag, " no request"}, g_valid, 0);
  endtask

  task automatic unlock();
    wr(20'h00555, 16'h00AA); exp_none("R2 unlock1");
    wr(20'h002AA, 16'h0055); exp_none("R2 unlock2");
  endtask

  task automatic erase_prefix();
    unlock();
    wr(20'h00555, 16'h0080); exp_none("R4 erase cycle3");
    unlock();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", req_valid, 0);
    chk("R1 ignored in reset", wr_ignored, 0);
    chk("R1 sp_mode in reset", sp_mode, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", req_valid, 0);
    chk("R1 sp_mode after reset", sp_mode, 0);
  endtask

  task automatic t_program();
    unlock();
    wr(20'h00555, 16'h00A0); exp_none("R3 cycle3");
    wr(20'h12345, 16'hBEEF); exp_req("R3 program", 4'd1, 20'h12345, 16'hBEEF);
    @(negedge clk);
    chk("R12 pulse one cycle", req_valid, 0);
  endtask

  task automatic t_mask();
    wr(20'hFF555, 16'h12AA); exp_none("R2 masked unlock1");
    wr(20'h00AAA, 16'h3355); exp_none("R2 AAA unlock2");
    wr(20'h80555, 16'h77A0); exp_none("R2 masked cycle3");
    wr(20'h00100, 16'h0001); exp_req("R2 masked program", 4'd1, 20'h00100, 16'h0001);
  endtask

  task automatic t_chip();
    erase_prefix();
    wr(20'h00555, 16'h0010); exp_req("R4 chip erase", 4'd2, 20'h00555, 16'h0010);
  endtask

  task automatic t_sector();
    erase_prefix();
    wr(20'h43210, 16'h0030); exp_req("R5 sector erase", 4'd3, 20'h43210, 16'h0030);
    erase_prefix();
    wr(20'h80001, 16'h0060); exp_req("R5 lockdown", 4'd4, 20'h80001, 16'h0060);
  endtask

  task automatic t_suspend();
    wr(20'h12345, 16'h00B0); exp_req("R6 suspend", 4'd5, 20'h12345, 16'h00B0);
    wr(20'hC0000, 16'h0030); exp_req("R6 resume", 4'd6, 20'hC0000, 16'h0030);
    chk("R6 resume plane3", g_plane, 2'd3);
    wr(20'h40123, 16'h0030); chk("R6 resume plane1", g_plane, 2'd1);
  endtask

  task automatic t_ident();
    unlock();
    wr(20'h00555, 16'h0090); exp_req("R7 id entry", 4'd7, 20'h00555, 16'h0090);
    unlock();
    wr(20'h00555, 16'h00F0); exp_req("R7 id exit long", 4'd8, 20'h00555, 16'h00F0);
    wr(20'h00777, 16'h00F0); exp_req("R7 id exit short", 4'd8, 20'h00777, 16'h00F0);
  endtask

  task automatic t_prot();
    unlock();
    wr(20'h00555, 16'h00C0); exp_none("R8 cycle3");
    wr(20'h00081, 16'h1234); exp_req("R8 prot program", 4'd9, 20'h00081, 16'h1234);
    unlock();
    wr(20'h00555, 16'h00C0);
    wr(20'h00080, 16'hFFFD); exp_req("R8 prot lock", 4'd10, 20'h00080, 16'hFFFD);
    unlock();
    wr(20'h00555, 16'h00C0);
    wr(20'h00080, 16'h0002); exp_none("R8 lock bit1 set");
  endtask

  task automatic t_busy();
    unlock();
    wr(20'h00555, 16'h00A0);
    wr(20'h00111, 16'h0022, 1'b1);
    chk("R10 ignored flag", g_ign, 1);
    exp_none("R10 busy write");
    wr(20'h00200, 16'h0003); exp_req("R10 sequence kept", 4'd1, 20'h00200, 16'h0003);
    chk("R10 flag cleared", g_ign, 0);
    wr(20'h00000, 16'h00F0, 1'b1); exp_none("R10 busy exit dropped");
  endtask

  task automatic t_break();
    wr(20'h00555, 16'h00AA);
    wr(20'h00555, 16'h00AA); exp_none("R11 bad second");
    wr(20'h002AA, 16'h0055); exp_none("R11 orphan unlock2");
    wr(20'h00555, 16'h00A0); exp_none("R11 orphan cycle3");
    wr(20'h00300, 16'h0044); exp_none("R11 orphan data");
    unlock();
    wr(20'h00555, 16'h0080);
    wr(20'h00123, 16'h0000); exp_none("R11 erase broken");
    wr(20'h002AA, 16'h0055); exp_none("R11 erase orphan");
  endtask

  task automatic t_single_pulse();
    erase_prefix();
    wr(20'h00555, 16'h00A0); exp_req("R9 sp enter", 4'd11, 20'h00555, 16'h00A0);
    chk("R9 sp_mode set", g_sp, 1);
    wr(20'h00555, 16'h00AA); exp_req("R9 sp unlock code", 4'd1, 20'h00555, 16'h00AA);
    wr(20'h00010, 16'h00B0); exp_req("R9 sp suspend code", 4'd1, 20'h00010, 16'h00B0);
    wr(20'hC0020, 16'h0030); exp_req("R9 sp resume code", 4'd1, 20'hC0020, 16'h0030);
    chk("R9 sp_mode held", g_sp, 1);
    do_reset();
    wr(20'h00010, 16'h00B0); exp_req("R9 after reset", 4'd5, 20'h00010, 16'h00B0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", req_valid, 0);
    chk("R1 sp_mode in reset", sp_mode, 0);
    rst = 1'b0;
    wr(20'h002AA, 16'h0055); exp_none("R1 idle after reset");
    t_program();
    t_mask();
    t_chip();
    t_sector();
    t_suspend();
    t_ident();
    t_prot();
    t_busy();
    t_break();
    t_single_pulse();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule